// File: doc/BRIEF.md
# Presence-Detect Memory Target

This block is a two-wire serial bus target that presents a 256-byte identification memory, such as the one a memory module carries to describe its geometry and timing to the host. SCL and SDA arrive as open-drain bus levels. The block never drives SDA high. It only asserts `sda_oe`, which the bus wiring turns into a pull to low. Both bus inputs pass through a two-stage synchroniser and a glitch filter before the block looks for edges. START and STOP are recognised as SDA edges that occur while SCL is high.

The memory is loaded from parameters at reset. The lower half is the factory region and is write-protected. The upper half is free for the host to use. One byte of the factory region holds the modulo-256 sum of all the bytes before it. The block recomputes that sum continuously and reports the result on `csum_ok`.

A host reaches the block with the 7-bit address formed by the fixed high nibble and the three strap bits. It can set the internal pointer with a written word address. It can read back at the pointer, either alone or after a repeated START. It can read any number of bytes in sequence, and it can write bytes.

Top module: `spd_target`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe` is 0, the internal pointer is 0, and the memory holds the parameter image.
- R2: The block acknowledges (drives SDA low in the ninth bit) only an address byte whose upper seven bits equal {DEV_HI, strap}. DEV_HI defaults to 4'b1010. Bit 0 is the direction: 1 means read, 0 means write. The block ignores any other address until the next START.
- R3: A write of an address byte followed by a word-address byte, then a repeated START and a read address byte, returns memory bytes MSB first, starting at that word address. The default image holds 0x80 at byte 0, 0x08 at byte 1, 0x07 at byte 2, 0x0D at byte 3, 0x0A at byte 4, 0x01 at byte 5, 0x40 at byte 6 and 0x04 at byte 17. Every other byte i except 63 holds (i*29 + FILL) mod 256, with FILL defaulting to 0x3C.
- R4: The pointer increments after every byte read and wraps from 255 to 0.
- R5: A read with no preceding word address starts at the current pointer.
- R6: A data byte written to an index from 128 to 255 is acknowledged and stored.
- R7: A data byte written to an index from 0 to 127 is not acknowledged (SDA stays high in the ninth bit), and the memory is left unchanged.
- R8: At reset, byte 63 is loaded with the sum of bytes 0..62 plus CSUM_ADJ (default 0). `csum_ok` is 1 exactly when byte 63 equals the modulo-256 sum of bytes 0..62.
- R9: A START or STOP is recognised only when the filtered SDA changes while the filtered SCL is high. An SDA pulse shorter than FILT_LEN clocks is ignored.
- R10: When the host does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R11: The pointer also increments after every written data byte, including a rejected one, and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Active-low reset that reloads the memory image |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| strap | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | 1 pulls SDA low |
| csum_ok | output | 1 | Factory checksum byte matches the computed sum |

## Verification
The bench places two instances on one shared open-drain bus, both with the default FILT_LEN of 4 and the default image. The first instance uses strap 3'b101 and CSUM_ADJ 0. The second uses strap 3'b010 and CSUM_ADJ 1, so it carries a deliberately wrong checksum byte. This arrangement lets the bench check `csum_ok` in both polarities and confirm that only the addressed instance answers. A bit period of 48 clocks leaves room for a two-clock SDA glitch during SCL high, which must not be taken as a START. The random mix of writes, random-address reads and current-address reads crosses both the lock boundary and the 255-to-0 wrap.

// File: rtl/spd_target.sv
module spd_target #(
  parameter int          ADDR_W     = 8,
  parameter int          LOCK_BYTES = 128,
  parameter int          CSUM_POS   = 63,
  parameter int          FILT_LEN   = 4,
  parameter logic [3:0]  DEV_HI     = 4'b1010,
  parameter logic [7:0]  FILL       = 8'h3C,
  parameter logic [7:0]  CSUM_ADJ   = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  output logic       sda_oe,
  output logic       csum_ok
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int FCW   = $clog2(FILT_LEN + 1);

  function automatic logic [7:0] image(int i);
    case (i)
      0:  image = 8'h80;
      1:  image = 8'h08;
      2:  image = 8'h07;
      3:  image = 8'h0D;
      4:  image = 8'h0A;
      5:  image = 8'h01;
      6:  image = 8'h40;
      17: image = 8'h04;
      default: image = 8'(i * 29) + FILL;
    endcase
  endfunction

  function automatic logic [7:0] image_sum();
    logic [7:0] a;
    a = 8'h00;
    for (int i = 0; i < CSUM_POS; i++) a = a + image(i);
    return a;
  endfunction

  localparam logic [7:0] CSUM_INIT = image_sum() + CSUM_ADJ;

  // input synchronisers and glitch filters, bit 0 = SCL, bit 1 = SDA
  logic [1:0] raw, s1, s2, flt, fltd;
  logic [FCW-1:0] fc [2];
  assign raw = {sda_i, scl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 2'b11;
      s2   <= 2'b11;
      fltd <= 2'b11;
    end else begin
      s1   <= raw;
      s2   <= s1;
      fltd <= flt;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt[g] <= 1'b1;
        fc[g]  <= '0;
      end else if (s2[g] == flt[g]) begin
        fc[g] <= '0;
      end else if (fc[g] == FCW'(FILT_LEN - 1)) begin
        flt[g] <= s2[g];
        fc[g]  <= '0;
      end else begin
        fc[g] <= fc[g] + 1'b1;
      end
    end
  end

  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
  assign scl_f     = flt[0];
  assign sda_f     = flt[1];
  assign scl_rise  = scl_f & ~fltd[0];
  assign scl_fall  = ~scl_f & fltd[0];
  assign start_det = scl_f & fltd[0] & fltd[1] & ~sda_f;
  assign stop_det  = scl_f & fltd[0] & ~fltd[1] & sda_f;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEVACK, S_WADR, S_WADRACK, S_WDAT, S_WDATACK, S_RDAT, S_RACK
  } st_t;

  st_t               st;
  logic [3:0]        bitc;
  logic [7:0]        shr, txr;
  logic [ADDR_W-1:0] ptr;
  logic              rw_q, mack_q, lock_hit_q, sda_oe_q;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bitc       <= '0;
      shr        <= '0;
      txr        <= '0;
      ptr        <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      lock_hit_q <= 1'b0;
      sda_oe_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i == CSUM_POS) ? CSUM_INIT : image(i);
    end else if (start_det) begin
      st       <= S_DEV;
      bitc     <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      st       <= S_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise) begin
            shr  <= {shr[6:0], sda_f};
            bitc <= bitc + 1'b1;
          end else if (scl_fall && bitc == 4'd8) begin
            if (st == S_DEV) begin
              if (shr[7:1] == {DEV_HI, strap}) begin
                sda_oe_q <= 1'b1;
                rw_q     <= shr[0];
                st       <= S_DEVACK;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_WADR) begin
              ptr      <= shr[ADDR_W-1:0];
              sda_oe_q <= 1'b1;
              st       <= S_WADRACK;
            end else begin
              if (int'(ptr) >= LOCK_BYTES) begin
                mem[ptr]   <= shr;
                sda_oe_q   <= 1'b1;
                lock_hit_q <= 1'b0;
              end else begin
                lock_hit_q <= 1'b1;
              end
              ptr <= ptr + 1'b1;
              st  <= S_WDATACK;
            end
          end
        end
        S_DEVACK: begin
          if (scl_fall) begin
            bitc <= '0;
            if (rw_q) begin
              sda_oe_q <= ~mem[ptr][7];
              txr      <= {mem[ptr][6:0], 1'b0};
              st       <= S_RDAT;
            end else begin
              sda_oe_q <= 1'b0;
              st       <= S_WADR;
            end
          end
        end
        S_WADRACK, S_WDATACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            bitc     <= '0;
            st       <= S_WDAT;
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            bitc <= bitc + 1'b1;
          end else if (scl_fall) begin
            if (bitc == 4'd8) begin
              sda_oe_q <= 1'b0;
              ptr      <= ptr + 1'b1;
              st       <= S_RACK;
            end else begin
              sda_oe_q <= ~txr[7];
              txr      <= {txr[6:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_f;
          end else if (scl_fall) begin
            bitc <= '0;
            if (mack_q) begin
              sda_oe_q <= ~mem[ptr][7];
              txr      <= {mem[ptr][6:0], 1'b0};
              st       <= S_RDAT;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] acc;
  always_comb begin
    acc = 8'h00;
    for (int i = 0; i < CSUM_POS; i++) acc = acc + mem[i];
  end

  assign csum_ok = (acc == mem[CSUM_POS]);
  assign sda_oe  = sda_oe_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe_q); // R10
  AST_ACK_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe_q) && st == S_DEVACK) |-> (shr[7:1] == {DEV_HI, strap})); // R2
  AST_LOCKED_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDATACK && lock_hit_q) |-> !sda_oe_q); // R7
  AST_CSUM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(csum_ok)); // R8
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr) == '1 && ptr != $past(ptr)) |-> (ptr == '0)); // R4
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(sda_oe_q) && !$past(start_det || stop_det)) |-> !scl_f); // R9
endmodule

// File: tb/spd_target_test.sv
`timescale 1ns/1ps
module spd_target_test;
  localparam int QP = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic oe_a, oe_b, ok_a, ok_b, sda_bus;
  assign sda_bus = m_sda & ~oe_a & ~oe_b;

  spd_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap(3'b101), .sda_oe(oe_a), .csum_ok(ok_a));

  spd_target #(.CSUM_ADJ(8'h01)) uut_b (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap(3'b010), .sda_oe(oe_b), .csum_ok(ok_b));

  int errs = 0, chks = 0, exp_ptr = 0;
  bit done = 1'b0;
  logic [7:0] mdl [256];
  logic [7:0] wbuf [4];

  function automatic logic [7:0] ref_byte(int i);
    case (i)
      0: return 8'h80;  1: return 8'h08;  2: return 8'h07;  3: return 8'h0D;
      4: return 8'h0A;  5: return 8'h01;  6: return 8'h40;  17: return 8'h04;
      default: return 8'((i * 29 + 60) % 256);
    endcase
  endfunction

  function automatic logic [7:0] ref_sum();
    int s = 0;
    for (int i = 0; i < 63; i++) s += int'(ref_byte(i));
    return 8'(s % 256);
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", rq, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QP) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait(); qwait();
  endtask

  task automatic wbit(input bit b, input bit glitch);
    m_sda = b; qwait(); m_scl = 1'b1; qwait();
    if (glitch) begin
      m_sda = 1'b0; repeat (2) @(negedge clk); m_sda = b;
    end
    qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic rbit(output bit b);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    b = sda_bus; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic wbyte(input logic [7:0] d, input int gbit, output bit ack);
    bit nb;
    for (int i = 0; i < 8; i++) wbit(d[7-i], i == gbit);
    rbit(nb);
    ack = ~nb;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 0; i < 8; i++) begin
      rbit(b);
      d[7-i] = b;
    end
    wbit(~ack, 1'b0);
  endtask

  task automatic addr_byte(input logic [2:0] s, input bit rd, input bit exp_ack, input string rq);
    bit ack;
    wbyte({4'b1010, s, rd}, -1, ack);
    check(ack == exp_ack, rq, ack, exp_ack);
  endtask

  task automatic set_ptr(input int adr);
    bit ack;
    addr_byte(3'b101, 1'b0, 1'b1, "R2");
    wbyte(8'(adr), -1, ack);
    check(ack, "R3", ack, 1);
    exp_ptr = adr;
  endtask

  task automatic read_n(input int n, input string rq);
    logic [7:0] d;
    addr_byte(3'b101, 1'b1, 1'b1, "R2");
    for (int k = 0; k < n; k++) begin
      rbyte(d, k != n - 1);
      check(d == mdl[exp_ptr], rq, d, mdl[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 256;
    end
  endtask

  task automatic read_at(input int adr, input int n, input string rq);
    i2c_start(); set_ptr(adr); i2c_start(); read_n(n, rq); i2c_stop();
  endtask

  task automatic cur_read(input int n, input string rq);
    i2c_start(); read_n(n, rq); i2c_stop();
  endtask

  task automatic write_at(input int adr, input int n, input int gbit, input string rq);
    bit ack;
    i2c_start(); set_ptr(adr);
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], (k == 0) ? gbit : -1, ack);
      check(ack == (exp_ptr >= 128), (exp_ptr >= 128) ? rq : "R7", ack, exp_ptr >= 128);
      if (exp_ptr >= 128) mdl[exp_ptr] = wbuf[k];
      exp_ptr = (exp_ptr + 1) % 256;
    end
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: act=0x0 exp=0x1");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    bit b;
    bit ack;
    logic [7:0] d;
    int ones;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) mdl[i] = ref_byte(i);
    mdl[63] = ref_sum();
    repeat (10) @(negedge clk);
    check(oe_a == 1'b0 && oe_b == 1'b0, "R1", {oe_b, oe_a}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(oe_a == 1'b0, "R1", oe_a, 0);
    check(ok_a == 1'b1, "R8", ok_a, 1);
    check(ok_b == 1'b0, "R8", ok_b, 0);

    cur_read(2, "R1");
    read_at(0, 7, "R3");
    read_at(17, 1, "R3");
    read_at(63, 1, "R8");
    read_at(254, 4, "R4");
    cur_read(2, "R5");

    wbuf[0] = 8'h5A;
    write_at(200, 1, -1, "R6");
    read_at(200, 1, "R6");

    wbuf[0] = ~mdl[10];
    write_at(10, 1, -1, "R7");
    read_at(10, 1, "R7");
    check(ok_a == 1'b1, "R8", ok_a, 1);

    wbuf[0] = 8'hC3; wbuf[1] = 8'h11;
    write_at(255, 2, -1, "R11");
    cur_read(1, "R11");
    read_at(255, 1, "R6");

    wbuf[0] = 8'hFF;
    write_at(150, 1, 2, "R9");
    read_at(150, 1, "R9");

    i2c_start(); addr_byte(3'b111, 1'b1, 1'b0, "R2"); i2c_stop();
    i2c_start(); wbyte(8'b1011_1011, -1, ack); check(!ack, "R2", ack, 0); i2c_stop();
    i2c_start(); addr_byte(3'b010, 1'b0, 1'b1, "R2");
    wbyte(8'd63, -1, ack);
    i2c_start(); addr_byte(3'b010, 1'b1, 1'b1, "R2");
    rbyte(d, 1'b0);
    check(d == ref_sum() + 8'h01, "R8", d, ref_sum() + 8'h01);
    i2c_stop();

    i2c_start(); read_n(1, "R10");
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      rbit(b);
      ones += int'(b);
    end
    check(ones == 9, "R10", ones, 9);
    i2c_stop();

    for (int it = 0; it < 24; it++) begin
      int op, adr, n;
      op  = $urandom_range(0, 2);
      adr = $urandom_range(0, 255);
      n   = $urandom_range(1, 4);
      if (op == 0) begin
        for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
        write_at(adr, n, -1, "R6");
      end else if (op == 1) begin
        read_at(adr, n, "R3");
      end else begin
        cur_read(n, "R5");
      end
    end
    check(ok_a == 1'b1, "R8", ok_a, 1);
    check(oe_a == 1'b0 && oe_b == 1'b0, "R10", {oe_b, oe_a}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule